// File: doc/BRIEF.md
# Frequency Sweep Controller with Bounded and Open-Ended Ramps

This block produces the frequency tuning word and the running phase for a direct digital synthesizer core. It has two sweep modes. In the bounded mode, the tuning word moves between a lower word and an upper word and stops exactly on whichever limit it is heading for. In the open-ended mode, the tuning word rises from the lower word with no ceiling. In both modes, one step of a programmable size is taken every time a programmable down-counter runs out.

A direction input picks the target limit in the bounded mode. Step size and step interval are captured on an update strobe, so a sweep can be made nonlinear by loading new values while it runs. Two clear controls are provided:

- A restart control sends the frequency back to its start point. It acts once when it rises, then again on each update strobe for as long as it is held high.
- A hold control keeps both accumulators at zero, which gives a 0 Hz output, for as long as it is high.

Top module: `fsk_chirp_sweep`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `freq_word` and `phase_acc` are zero.
- R2: `step_word` and `rate_word` are captured on a cycle where `upd_strobe` is high. With a captured rate of N, a frequency step occurs once every N+1 clock cycles.
- R3: In bounded mode (`mode_chirp`=0), each step moves the word up by the step when `fsk_sel`=1, or down by the step when `fsk_sel`=0. The result is clamped exactly into [`f1_word`, `f2_word`] (with `f1_word` <= `f2_word`), so F1 to F2 is reached in ceil((F2-F1)/step) steps.
- R4: A change of `fsk_sel` in bounded mode reverses the ramp from the current word, with no restart.
- R5: In open-ended mode (`mode_chirp`=1), each step adds the step modulo 2^FREQ_W. Both `fsk_sel` and `f2_word` are ignored.
- R6: A rising edge of `clr_ramp`, or an `upd_strobe` while `clr_ramp` stays high, sets `freq_word` to its start point on the next cycle and reloads the interval counter. The start point is `f1_word` in bounded mode with `fsk_sel`=1, `f2_word` in bounded mode with `fsk_sel`=0, and `f1_word` in open-ended mode. A held `clr_ramp` causes no restart on cycles without a strobe.
- R7: While `clr_all` is high, `freq_word` and `phase_acc` are zero from the next cycle on. After release, ramping resumes from zero; in bounded mode the first step lands inside the limits.
- R8: Each cycle, `phase_acc` adds the current `freq_word`, zero-extended to PHASE_W bits, modulo 2^PHASE_W.
- R9: A restart from `clr_ramp` still takes effect after the word has settled on a limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_chirp | input | 1 | 0 = bounded sweep, 1 = open-ended sweep |
| fsk_sel | input | 1 | Bounded-mode direction: 1 toward `f2_word`, 0 toward `f1_word` |
| f1_word | input | FREQ_W | Lower limit and start word |
| f2_word | input | FREQ_W | Upper limit |
| step_word | input | FREQ_W | Step size, captured on strobe |
| rate_word | input | RATE_W | Step interval minus one, captured on strobe |
| upd_strobe | input | 1 | Update strobe |
| clr_ramp | input | 1 | Ramp restart control |
| clr_all | input | 1 | Hold both accumulators at zero |
| freq_word | output | FREQ_W | Current frequency tuning word |
| phase_acc | output | PHASE_W | Phase accumulator |

## Verification
The bench builds the block with FREQ_W=16, PHASE_W=20 and RATE_W=4. A 16-bit word lets the open-ended sweep wrap within a few cycles. A 4-bit interval makes every rate from 0 to 15 reachable, so random runs hit clamping, reversal and restarts on every interval phase. The wider phase accumulator exercises the zero-extension path.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic {
        SWEEP_BOUNDED = 1'b0,
        SWEEP_OPEN    = 1'b1
    } sweep_mode_e;

    typedef struct packed {
        logic hold_zero;
        logic ramp_restart;
    } clr_cmd_t;

    localparam int unsigned DEF_FREQ_W  = 48;
    localparam int unsigned DEF_PHASE_W = 48;
    localparam int unsigned DEF_RATE_W  = 20;

endpackage

// File: rtl/sweep_rate_timer.sv
module sweep_rate_timer #(
    parameter int unsigned RATE_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_q,
    input  logic              restart,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;

    assign tick = (cnt_q == '0) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == '0) begin
            cnt_q <= rate_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sweep_clr_gen.sv
module sweep_clr_gen
    import sweep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_ramp,
    input  logic     clr_all,
    input  logic     upd_strobe,
    output clr_cmd_t cmd
);
    logic ramp_prev_q;

    always_ff @(posedge clk) begin
        if (rst) ramp_prev_q <= 1'b0;
        else     ramp_prev_q <= clr_ramp;
    end

    always_comb begin
        cmd.hold_zero    = clr_all;
        cmd.ramp_restart = clr_ramp && (!ramp_prev_q || upd_strobe);
    end
endmodule

// File: rtl/sweep_next_freq.sv
module sweep_next_freq
    import sweep_pkg::*;
#(
    parameter int unsigned FREQ_W = 48
) (
    input  sweep_mode_e       mode,
    input  logic              fsk_sel,
    input  logic [FREQ_W-1:0] f1,
    input  logic [FREQ_W-1:0] f2,
    input  logic [FREQ_W-1:0] step,
    input  logic [FREQ_W-1:0] freq,
    output logic [FREQ_W-1:0] nxt,
    output logic [FREQ_W-1:0] start
);
    localparam int unsigned XW = FREQ_W + 1;

    logic [XW-1:0]     up_c, dn_c, cand, f1x, f2x;
    logic [FREQ_W-1:0] bounded_nxt;

    always_comb begin
        f1x  = {1'b0, f1};
        f2x  = {1'b0, f2};
        up_c = {1'b0, freq} + {1'b0, step};
        dn_c = (freq < step) ? '0 : {1'b0, freq - step};
        cand = fsk_sel ? up_c : dn_c;
        if (cand > f2x)      bounded_nxt = f2;
        else if (cand < f1x) bounded_nxt = f1;
        else                 bounded_nxt = cand[FREQ_W-1:0];

        if (mode == SWEEP_OPEN) begin
            nxt   = freq + step;
            start = f1;
        end else begin
            nxt   = bounded_nxt;
            start = fsk_sel ? f1 : f2;
        end
    end
endmodule

// File: rtl/fsk_chirp_sweep.sv
module fsk_chirp_sweep
    import sweep_pkg::*;
#(
    parameter int unsigned FREQ_W  = DEF_FREQ_W,
    parameter int unsigned PHASE_W = DEF_PHASE_W,
    parameter int unsigned RATE_W  = DEF_RATE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_chirp,
    input  logic               fsk_sel,
    input  logic [FREQ_W-1:0]  f1_word,
    input  logic [FREQ_W-1:0]  f2_word,
    input  logic [FREQ_W-1:0]  step_word,
    input  logic [RATE_W-1:0]  rate_word,
    input  logic               upd_strobe,
    input  logic               clr_ramp,
    input  logic               clr_all,
    output logic [FREQ_W-1:0]  freq_word,
    output logic [PHASE_W-1:0] phase_acc
);
    sweep_mode_e       mode;
    clr_cmd_t          clr;
    logic [FREQ_W-1:0] step_q, freq_q, freq_nxt, freq_start;
    logic [RATE_W-1:0] rate_q;
    logic              tick;
    logic [PHASE_W-1:0] phase_q, phase_inc;

    assign mode = sweep_mode_e'(mode_chirp);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            rate_q <= '0;
        end else if (upd_strobe) begin
            step_q <= step_word;
            rate_q <= rate_word;
        end
    end

    sweep_clr_gen u_clr (
        .clk        (clk),
        .rst        (rst),
        .clr_ramp   (clr_ramp),
        .clr_all    (clr_all),
        .upd_strobe (upd_strobe),
        .cmd        (clr)
    );

    sweep_rate_timer #(.RATE_W(RATE_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .rate_q  (rate_q),
        .restart (clr.hold_zero || clr.ramp_restart),
        .tick    (tick)
    );

    sweep_next_freq #(.FREQ_W(FREQ_W)) u_next (
        .mode    (mode),
        .fsk_sel (fsk_sel),
        .f1      (f1_word),
        .f2      (f2_word),
        .step    (step_q),
        .freq    (freq_q),
        .nxt     (freq_nxt),
        .start   (freq_start)
    );

    always_ff @(posedge clk) begin
        if (rst || clr.hold_zero) freq_q <= '0;
        else if (clr.ramp_restart) freq_q <= freq_start;
        else if (tick)             freq_q <= freq_nxt;
    end

    generate
        if (PHASE_W > FREQ_W) begin : g_phase_ext
            assign phase_inc = {{(PHASE_W-FREQ_W){1'b0}}, freq_q};
        end else if (PHASE_W == FREQ_W) begin : g_phase_eq
            assign phase_inc = freq_q;
        end else begin : g_phase_trunc
            assign phase_inc = freq_q[FREQ_W-1 -: PHASE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr.hold_zero) phase_q <= '0;
        else                      phase_q <= phase_q + phase_inc;
    end

    assign freq_word = freq_q;
    assign phase_acc = phase_q;
endmodule

// File: rtl/fsk_chirp_sweep_chk.sv
module fsk_chirp_sweep_chk #(
    parameter int unsigned FREQ_W  = 48,
    parameter int unsigned PHASE_W = 48
) (
    input logic               clk,
    input logic               rst,
    input logic               mode_chirp,
    input logic               fsk_sel,
    input logic [FREQ_W-1:0]  f1_word,
    input logic [FREQ_W-1:0]  f2_word,
    input logic               upd_strobe,
    input logic               clr_ramp,
    input logic               clr_all,
    input logic [FREQ_W-1:0]  freq_word,
    input logic [PHASE_W-1:0] phase_acc
);
    logic              ramp_seen_q;
    logic [FREQ_W-1:0] exp_start;

    always_ff @(posedge clk) begin
        if (rst) ramp_seen_q <= 1'b0;
        else     ramp_seen_q <= clr_ramp;
    end

    assign exp_start = (mode_chirp || fsk_sel) ? f1_word : f2_word;

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (freq_word == '0 && phase_acc == '0)); // R7

    AST_BOUNDED_CEIL: assert property (@(posedge clk) disable iff (rst)
        (!clr_all && !mode_chirp && f1_word <= f2_word && freq_word <= f2_word)
        |=> (freq_word <= $past(f2_word))); // R3

    AST_BOUNDED_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (!clr_all && !mode_chirp && f1_word <= f2_word && freq_word >= f1_word)
        |=> (freq_word >= $past(f1_word))); // R3

    AST_RESTART_POINT: assert property (@(posedge clk) disable iff (rst)
        (!clr_all && clr_ramp && (!ramp_seen_q || upd_strobe))
        |=> (freq_word == $past(exp_start))); // R6

    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!clr_all && freq_word == '0) |=> $stable(phase_acc)); // R8
endmodule

bind fsk_chirp_sweep fsk_chirp_sweep_chk #(
    .FREQ_W  (FREQ_W),
    .PHASE_W (PHASE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_chirp (mode_chirp),
    .fsk_sel    (fsk_sel),
    .f1_word    (f1_word),
    .f2_word    (f2_word),
    .upd_strobe (upd_strobe),
    .clr_ramp   (clr_ramp),
    .clr_all    (clr_all),
    .freq_word  (freq_word),
    .phase_acc  (phase_acc)
);

// File: tb/fsk_chirp_sweep_bench.sv
module fsk_chirp_sweep_bench;
    localparam int FW = 16;
    localparam int PW = 20;
    localparam int RW = 4;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_chirp = 1'b0, fsk_sel = 1'b0;
    logic [FW-1:0] f1_word = '0, f2_word = '0, step_word = '0;
    logic [RW-1:0] rate_word = '0;
    logic          upd_strobe = 1'b0, clr_ramp = 1'b0, clr_all = 1'b0;
    logic [FW-1:0] freq_word;
    logic [PW-1:0] phase_acc;

    int checks = 0, fails = 0;
    bit done = 1'b0, live = 1'b0;
    string cur_req = "R2";

    // reference model state
    logic [FW-1:0] m_freq = '0, m_step = '0;
    logic [RW-1:0] m_rate = '0, m_cnt = '0;
    logic [PW-1:0] m_phase = '0;
    logic          m_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_chirp_sweep #(.FREQ_W(FW), .PHASE_W(PW), .RATE_W(RW)) u_fsk_chirp_sweep (
        .clk(clk), .rst(rst), .mode_chirp(mode_chirp), .fsk_sel(fsk_sel),
        .f1_word(f1_word), .f2_word(f2_word), .step_word(step_word),
        .rate_word(rate_word), .upd_strobe(upd_strobe), .clr_ramp(clr_ramp),
        .clr_all(clr_all), .freq_word(freq_word), .phase_acc(phase_acc)
    );

    function automatic logic [FW-1:0] ref_step(logic [FW-1:0] f, logic [FW-1:0] s);
        longint c;
        if (mode_chirp) return f + s;
        c = fsk_sel ? longint'(f) + longint'(s) : longint'(f) - longint'(s);
        if (c > longint'(f2_word)) return f2_word;
        if (c < longint'(f1_word)) return f1_word;
        return c[FW-1:0];
    endfunction

    function automatic logic [FW-1:0] ref_start();
        return (mode_chirp || fsk_sel) ? f1_word : f2_word;
    endfunction

    always @(posedge clk) begin
        logic pulse, tick;
        if (rst) begin
            m_freq = '0; m_step = '0; m_rate = '0; m_cnt = '0; m_phase = '0; m_prev = 1'b0;
        end else begin
            pulse = clr_ramp && (!m_prev || upd_strobe);
            tick  = (m_cnt == '0) && !(clr_all || pulse);
            m_phase = clr_all ? '0 : m_phase + PW'(m_freq);
            if (clr_all)    m_freq = '0;
            else if (pulse) m_freq = ref_start();
            else if (tick)  m_freq = ref_step(m_freq, m_step);
            if (clr_all || pulse || m_cnt == '0) m_cnt = m_rate;
            else m_cnt = m_cnt - 1'b1;
            if (upd_strobe) begin m_step = step_word; m_rate = rate_word; end
            m_prev = clr_ramp;
        end
    end

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && !rst) begin
            check(cur_req, freq_word, m_freq);
            check("R8", phase_acc, m_phase);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(logic [FW-1:0] s, logic [RW-1:0] r);
        step_word = s; rate_word = r; upd_strobe = 1'b1;
        cyc(1);
        upd_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        int chg;
        logic [FW-1:0] last;
        cyc(3);
        check("R1", freq_word, 0);
        check("R1", phase_acc, 0);
        rst = 1'b0;
        cyc(1);
        check("R1", freq_word, 0);
        check("R1", phase_acc, 0);
        live = 1'b1;

        // R3: bounded ramp to upper limit, exact clamp and step count
        cur_req = "R3";
        f1_word = 100; f2_word = 1000; fsk_sel = 1'b1;
        load(130, 2);
        clr_ramp = 1'b1; cyc(1); clr_ramp = 1'b0;
        check("R6", freq_word, 100);
        chg = 0; last = freq_word;
        for (int i = 0; i < 40; i++) begin
            cyc(1);
            if (freq_word != last) chg++;
            last = freq_word;
        end
        check("R3", chg, 7);
        check("R3", freq_word, 1000);

        // R4: reversal from the current word
        cur_req = "R4";
        fsk_sel = 1'b0;
        cyc(9);
        check("R4", (freq_word < 1000 && freq_word >= 1000 - 3*130) ? 1 : 0, 1);
        cyc(40);
        check("R3", freq_word, 100);

        // R9/R6: restart while parked on a limit, then hold with strobes
        cur_req = "R6";
        clr_ramp = 1'b1; cyc(1);
        check("R9", freq_word, 1000);
        cyc(10);
        check("R6", (freq_word < 1000) ? 1 : 0, 1);
        upd_strobe = 1'b1; cyc(1); upd_strobe = 1'b0;
        check("R6", freq_word, 1000);
        clr_ramp = 1'b0;

        // R7: hold both accumulators at zero
        cur_req = "R7";
        cyc(5);
        clr_all = 1'b1;
        for (int i = 0; i < 5; i++) begin
            cyc(1);
            check("R7", freq_word, 0);
            check("R7", phase_acc, 0);
        end
        clr_all = 1'b0;
        cyc(1);
        check("R7", freq_word, 0);
        cyc(5);
        check("R7", freq_word, 100);

        // R5: open-ended sweep wraps and ignores f2 and direction
        cur_req = "R5";
        mode_chirp = 1'b1; f2_word = 200;
        load(5000, 0);
        clr_ramp = 1'b1; cyc(1); clr_ramp = 1'b0;
        check("R5", freq_word, 100);
        cyc(20);
        check("R5", freq_word, (100 + 20*5000) % 65536);

        // R2: nonlinear sweep by loading new step and interval mid-run
        cur_req = "R2";
        load(7, 3);
        cyc(12);
        load(300, 1);
        cyc(12);

        // constrained random mix
        cur_req = "R2";
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            logic [FW-1:0] a, b;
            if ($urandom_range(0, 63) == 0) begin
                a = FW'($urandom); b = FW'($urandom);
                f1_word = (a < b) ? a : b; f2_word = (a < b) ? b : a;
            end
            if ($urandom_range(0, 99) == 0) mode_chirp = ~mode_chirp;
            if ($urandom_range(0, 19) == 0) fsk_sel = ~fsk_sel;
            upd_strobe = ($urandom_range(0, 9) == 0);
            if (upd_strobe) begin
                step_word = FW'($urandom_range(0, 4000));
                rate_word = RW'($urandom);
            end
            if ($urandom_range(0, 29) == 0) clr_ramp = ~clr_ramp;
            clr_all = ($urandom_range(0, 99) < 2);
            cyc(1);
        end
        done = 1'b1;
        finish_run();
    end
endmodule